// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a serial memory's bus engine and its storage array. A write command first loads the word-address pointer. The data bytes that follow are then collected in a page buffer at the pointer's in-page position. Only the in-page bits of the pointer advance, so the buffer wraps around inside the current page. Bytes beyond one page replace the earliest ones. A per-slot received mask records which positions hold real data.

When the bus engine reports a Stop and at least one byte has been received, the block starts a self-timed programming cycle and raises `busy`. The bus engine uses `busy` to withhold acknowledges. During the first page-size cycles of that interval, the block sweeps the buffer and issues one array write for each received slot. The remaining cycles fill out the programmed write time, which is a parameter counted in clock cycles.

The upper half of the address space is permanently write-inhibited. A low-supply indication blocks both the start of programming and any array write. `PAGE_BYTES` selects an 8-byte or a 16-byte page.

Top module: `page_write_ctl`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and `addr_ptr` is 0.
- R2: While idle, `addr_load` copies `addr_in` into `addr_ptr` on the next clock and discards any bytes already buffered.
- R3: While idle, each `byte_stb` adds 1 modulo `PAGE_BYTES` to the low log2(`PAGE_BYTES`) bits of `addr_ptr` and leaves the upper bits unchanged, so the address wraps to the start of the same page.
- R4: When more than `PAGE_BYTES` bytes arrive before Stop, each later byte replaces the byte held at its slot, so only the last `PAGE_BYTES` bytes are programmed.
- R5: A `stop_evt` with at least one buffered byte and `supply_low` at 0 raises `busy` on the next clock. `busy` then stays high for exactly max(`WRITE_CYCLES`, `PAGE_BYTES`) cycles.
- R6: During that cycle, the block issues one `arr_we` pulse for each received slot, in ascending slot order. The pulse for slot k falls in the k-th busy cycle (counting from 0), with `arr_addr` = {page bits of `addr_ptr`, k} and `arr_wdata` = the byte held for slot k. Slots that were not received are never written.
- R7: If address bit 7 (the top address bit) of the page is 1, no `arr_we` pulse is issued. The programming cycle and its `busy` interval still run.
- R8: A `stop_evt` while `supply_low` is 1 discards the buffer and starts no cycle. While `supply_low` is 1 during a cycle, `arr_we` stays 0.
- R9: A `stop_evt` with no buffered byte starts no cycle. `abort_evt` discards the buffered bytes and starts no cycle, and in both cases `addr_ptr` keeps its value.
- R10: While `busy` is 1, `addr_load` and `byte_stb` are ignored: `addr_ptr` is unchanged, and the byte is neither buffered nor written.
- R11: When `busy` falls, `addr_ptr` still holds the position after the last received byte, and the buffer is empty. A later byte without a new address load therefore lands at that position and is programmed alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load the word-address pointer |
| addr_in | input | ADDR_W | Word address to load |
| byte_stb | input | 1 | One received data byte is valid |
| byte_in | input | DATA_W | Received data byte |
| stop_evt | input | 1 | Stop condition seen on the bus |
| abort_evt | input | 1 | Transfer abandoned; drop buffered bytes |
| supply_low | input | 1 | Supply below the programming threshold |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| addr_ptr | output | ADDR_W | Current word-address pointer |

## Verification
The assertions rely on the bus engine presenting at most one of `addr_load`, `byte_stb`, `stop_evt` and `abort_evt` in any cycle. This property is itself checked as an input precondition. The pointer-stability and wrap properties depend on it.

The stimulus tasks drive each event as a separate one-cycle pulse. This holds even for the address loads and bytes poked into an active programming cycle. `supply_low` changes only between events, or right after a cycle has started.

// File: rtl/page_write_ctl.sv
module page_write_ctl #(
  parameter int PAGE_BYTES   = 16,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 375000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_evt,
  input  logic              abort_evt,
  input  logic              supply_low,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0] addr_ptr
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int HOLD  = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(HOLD - 1);
  localparam logic [CNT_W-1:0] SWEEP = CNT_W'(PAGE_BYTES);

  logic [ADDR_W-1:0]     ptr;
  logic [PAGE_BYTES-1:0] held;
  logic [DATA_W-1:0]     slot [PAGE_BYTES];
  logic                  run;
  logic [CNT_W-1:0]      cnt;

  wire [IDX_W-1:0] wr_idx = ptr[IDX_W-1:0];
  wire [IDX_W-1:0] rd_idx = cnt[IDX_W-1:0];
  wire             locked = ptr[ADDR_W-1];
  wire             take   = !run && !addr_load && byte_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      held <= '0;
      run  <= 1'b0;
      cnt  <= '0;
    end else if (run) begin
      if (cnt == LAST) begin
        run  <= 1'b0;
        cnt  <= '0;
        held <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (addr_load) begin
      ptr  <= addr_in;
      held <= '0;
    end else if (byte_stb) begin
      held[wr_idx]       <= 1'b1;
      ptr[IDX_W-1:0]     <= wr_idx + IDX_W'(1);
    end else if (stop_evt) begin
      if (|held && !supply_low) run <= 1'b1;
      else                      held <= '0;
    end else if (abort_evt) begin
      held <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) slot[wr_idx] <= byte_in;
  end

  assign busy      = run;
  assign arr_we    = run && (cnt < SWEEP) && held[rd_idx] && !locked && !supply_low;
  assign arr_addr  = {ptr[ADDR_W-1:IDX_W], rd_idx};
  assign arr_wdata = slot[rd_idx];
  assign addr_ptr  = ptr;
endmodule

// File: rtl/page_write_ctl_chk.sv
module page_write_ctl_chk #(
  parameter int PAGE_BYTES   = 16,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 375000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic              byte_stb,
  input logic              stop_evt,
  input logic              abort_evt,
  input logic              supply_low,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_wdata,
  input logic [ADDR_W-1:0] addr_ptr
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int HOLD  = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;

  logic [31:0] span;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span <= '0;
    else if (busy) span <= span + 1;
    else           span <= '0;
  end

  // R2 R3 R9 input precondition
  input_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, byte_stb, stop_evt, abort_evt}));

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !busy) |=>
      (addr_ptr[ADDR_W-1:IDX_W] == $past(addr_ptr[ADDR_W-1:IDX_W])) &&
      (addr_ptr[IDX_W-1:0] == IDX_W'($past(addr_ptr[IDX_W-1:0]) + 1'b1)));

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt) && !$past(supply_low));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> span == HOLD);

  // R6
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy && span < PAGE_BYTES);

  // R7
  no_upper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !arr_addr[ADDR_W-1]);

  // R8
  low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !arr_we);

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_ptr));
endmodule

bind page_write_ctl page_write_ctl_chk #(
  .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .byte_stb(byte_stb),
  .stop_evt(stop_evt), .abort_evt(abort_evt), .supply_low(supply_low),
  .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
  .addr_ptr(addr_ptr)
);

// File: tb/page_write_ctl_bench.sv
module page_write_ctl_bench;
  localparam int PG   = 16;
  localparam int WC   = 40;
  localparam int HOLD = (WC > PG) ? WC : PG;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_stb = 0, stop_evt = 0, abort_evt = 0, supply_low = 0;
  logic [7:0] addr_in = 0, byte_in = 0;
  logic busy, arr_we;
  logic [7:0] arr_addr, arr_wdata, addr_ptr;

  page_write_ctl #(.PAGE_BYTES(PG), .ADDR_W(8), .DATA_W(8), .WRITE_CYCLES(WC)) u_page_write_ctl (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .stop_evt(stop_evt), .abort_evt(abort_evt),
    .supply_low(supply_low), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .addr_ptr(addr_ptr));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] expq [$];
  logic [7:0]  m_ptr;
  logic [7:0]  m_slot [PG];
  logic [PG-1:0] m_held;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      // R6 scoreboard compare
      if (expq.size() == 0) chk("R6 unexpected write", {arr_addr, arr_wdata}, 32'hFFFF_FFFF);
      else chk("R6 write addr/data", {16'h0, arr_addr, arr_wdata}, {16'h0, expq.pop_front()});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [7:0] a);
    addr_in = a; addr_load = 1; tick(); addr_load = 0;
    m_ptr = a; m_held = '0;
  endtask

  task automatic put(input logic [7:0] b);
    byte_in = b; byte_stb = 1; tick(); byte_stb = 0;
    m_slot[m_ptr[3:0]] = b; m_held[m_ptr[3:0]] = 1'b1;
    m_ptr[3:0] = m_ptr[3:0] + 4'd1;
  endtask

  task automatic do_stop(input string req, input bit drop_supply, input bit poke);
    bit go;
    int n;
    go = (m_held != 0) && !supply_low;
    if (go && !drop_supply && !m_ptr[7])
      for (int k = 0; k < PG; k++)
        if (m_held[k]) expq.push_back({m_ptr[7:4], 4'(k), m_slot[k]});
    stop_evt = 1; tick(); stop_evt = 0;
    if (go) begin
      if (drop_supply) supply_low = 1;
      n = 0;
      forever begin
        @(negedge clk);
        if (!busy || n > HOLD + 4) break;
        n++;
        if (poke) begin
          if (n == 3) begin addr_in = 8'h70; addr_load = 1; end
          if (n == 4) begin addr_load = 0; byte_in = 8'h99; byte_stb = 1; end
          if (n == 5) byte_stb = 0;
        end
      end
      supply_low = 0;
      chk({req, " R5 busy length"}, n, HOLD);
      chk({req, " R11 ptr after cycle"}, addr_ptr, m_ptr);
      chk({req, " R6 all writes seen"}, expq.size(), 0);
    end else begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk({req, " no cycle"}, busy, 0);
      end
      chk({req, " ptr kept"}, addr_ptr, m_ptr);
    end
    m_held = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_ptr = 0; m_held = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 we", arr_we, 0);
    chk("R1 ptr", addr_ptr, 0);

    load(8'h10);
    @(negedge clk); chk("R2 load", addr_ptr, 8'h10);
    put(8'hAA); put(8'hBB); put(8'hCC);
    @(negedge clk); chk("R3 advance", addr_ptr, 8'h13);
    do_stop("R6 short page", 0, 0);

    load(8'h2E);
    for (int i = 0; i < 5; i++) put(8'hA0 + 8'(i));
    @(negedge clk); chk("R3 in-page wrap", addr_ptr, 8'h23);
    do_stop("R6 wrapped order", 0, 0);

    load(8'h40);
    for (int i = 0; i < 20; i++) put(8'h60 + 8'(i));
    @(negedge clk); chk("R4 overflow ptr", addr_ptr, 8'h44);
    do_stop("R4 overwrite", 0, 0);

    load(8'h90); put(8'h11); put(8'h22);
    do_stop("R7 protected", 0, 0);

    load(8'h05);
    do_stop("R9 empty stop", 0, 0);
    put(8'h33); put(8'h44);
    abort_evt = 1; tick(); abort_evt = 0; m_held = '0;
    do_stop("R9 after abort", 0, 0);

    load(8'h30); put(8'h55);
    supply_low = 1;
    do_stop("R8 low at stop", 0, 0);
    supply_low = 0;
    do_stop("R8 buffer dropped", 0, 0);

    load(8'h50); put(8'h66); put(8'h77);
    do_stop("R8 low in cycle", 1, 0);

    load(8'h60); put(8'h12);
    do_stop("R10 poke while busy", 0, 1);
    chk("R10 ptr ignored", addr_ptr, 8'h61);
    put(8'h34);
    do_stop("R11 follow-on byte", 0, 0);

    repeat (3) @(negedge clk);
    chk("R6 queue drained", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule